// File: doc/BRIEF.md
# Rotating-Priority Request Arbiter

This block picks one winner among DEPTH request lines each cycle and rotates the priority so that no requester can be starved. A register holds the index of the most recent winner. In each cycle the search starts at the line just above that index and moves upward, wrapping past the top line back to line 0. The stored index is therefore the last position to be considered.

The winner is found without a serial scan. A comparator bank marks every line whose index is strictly greater than the stored index. Two trailing-zero trees of logarithmic depth run side by side: one on the masked requests and one on the full request vector. If any masked request is active, the masked result is chosen; otherwise the full-vector result supplies the wraparound. DEPTH need not be a power of two. The trees are padded internally to the next power of two.

The grant index and the next-pointer value are combinational outputs of the current requests and the stored pointer. A surrounding client uses the grant in the same cycle. The pointer register takes the next-pointer value at the clock edge.

Top module: `rotary_grant_arb`

## Requirements
- R1: When at least one request is active, the grant is the lowest-indexed active line whose index is strictly greater than the stored pointer. If there is no such line, the grant is the lowest-indexed active line overall, so the line at the pointer itself is considered last.
- R2: When no request is active, the grant output is 0 and the next-pointer output equals the stored pointer.
- R3: When at least one request is active, the next-pointer output equals the grant index.
- R4: While the active-high synchronous reset is 1 at a rising clock edge, the stored pointer becomes 0. With no request active, this is visible on the next-pointer output in the following cycle.
- R5: At every rising edge with reset low, the stored pointer takes the next-pointer value presented in that cycle. It changes only when that value differs from the current pointer.
- R6: For any DEPTH, including values that are not a power of two, the grant and the stored pointer are always below DEPTH. Request bits of the padded positions never win.
- R7: The order is an upward rotation, so it differs from a downward rotation and from a fixed lowest-index-first order. For example, with the pointer at 5 and DEPTH 13, requests on lines 3 and 4 grant line 3. With the pointer at 1, requests on lines 1 and 2 grant line 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the stored pointer |
| req | input | DEPTH | Request lines, bit i is requester i |
| grant | output | clog2(DEPTH) | Binary index of the winning request, 0 when idle |
| ptr_next | output | clog2(DEPTH) | Value the stored pointer takes at the next edge |

## Verification
The bound checker verifies the following every cycle:
- an active request always yields a grant that points at an asserted line below DEPTH;
- when requests are active, the next pointer follows the grant;
- when idle, the outputs hold at 0 and the stored pointer;
- the stored pointer clears after reset and otherwise takes the previous next-pointer value.

The checker cannot show that the winner is the correct one in rotation order. The bench shows this by comparing four instances of DEPTH 7, 8, 13 and 16 against a looping reference model under random traffic with resets in the middle of the run. Hand-worked vectors separate the upward rotation from the downward and fixed-priority orders.

// File: rtl/rga_pkg.sv
`timescale 1ns/1ps
package rga_pkg;
  // Index width for a given number of request lines (at least one bit).
  function automatic int idx_width(input int lines);
    return (lines < 2) ? 1 : $clog2(lines);
  endfunction
endpackage

// File: rtl/rga_above_mask.sv
`timescale 1ns/1ps
// Marks every line whose index lies strictly above the stored pointer.
module rga_above_mask #(
  parameter int DEPTH = 13,
  parameter int IW    = 4
) (
  input  logic [IW-1:0]    ptr,
  output logic [DEPTH-1:0] above
);
  genvar gi;
  for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
    assign above[gi] = (IW'(gi) > ptr);
  end
endmodule

// File: rtl/rga_tz_tree.sv
`timescale 1ns/1ps
// Log-depth lowest-set-bit finder. Input is padded to 2**IW lines.
module rga_tz_tree #(
  parameter int W  = 13,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] pos
);
  localparam int P = 1 << IW;

  logic [P-1:0] padded;
  if (P > W) begin : g_pad
    assign padded = {{(P-W){1'b0}}, vec};
  end else begin : g_nopad
    assign padded = vec;
  end

  genvar lv, nd;
  for (lv = 0; lv <= IW; lv++) begin : g_lv
    localparam int NN = P >> lv;
    logic [NN-1:0] vv;
    logic [IW-1:0] xx [NN];
    for (nd = 0; nd < NN; nd++) begin : g_nd
      if (lv == 0) begin : g_leaf
        assign vv[nd] = padded[nd];
        assign xx[nd] = '0;
      end else begin : g_join
        // Lower half wins; upper half adds its half-size offset.
        assign vv[nd] = g_lv[lv-1].vv[2*nd] | g_lv[lv-1].vv[2*nd+1];
        assign xx[nd] = g_lv[lv-1].vv[2*nd] ? g_lv[lv-1].xx[2*nd]
                      : (g_lv[lv-1].xx[2*nd+1] | IW'(1 << (lv-1)));
      end
    end
  end

  assign hit = g_lv[IW].vv[0];
  assign pos = g_lv[IW].xx[0];
endmodule

// File: rtl/rga_pick.sv
`timescale 1ns/1ps
// Runs the upper-region search and the full-vector search in parallel.
module rga_pick #(
  parameter int DEPTH = 13,
  parameter int IW    = 4
) (
  input  logic [DEPTH-1:0] req,
  input  logic [DEPTH-1:0] above,
  output logic             any,
  output logic [IW-1:0]    win
);
  logic [DEPTH-1:0] upper;
  logic             up_hit;
  logic [IW-1:0]    up_pos;
  logic [IW-1:0]    all_pos;

  assign upper = req & above;

  rga_tz_tree #(.W(DEPTH), .IW(IW)) u_upper (
    .vec (upper),
    .hit (up_hit),
    .pos (up_pos)
  );

  rga_tz_tree #(.W(DEPTH), .IW(IW)) u_full (
    .vec (req),
    .hit (any),
    .pos (all_pos)
  );

  assign win = up_hit ? up_pos : all_pos;
endmodule

// File: rtl/rotary_grant_arb.sv
`timescale 1ns/1ps
module rotary_grant_arb #(
  parameter int DEPTH = 13,
  localparam int IW   = rga_pkg::idx_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] req,
  output logic [IW-1:0]    grant,
  output logic [IW-1:0]    ptr_next
);
  logic [IW-1:0]    ptr_q;
  logic [DEPTH-1:0] above;
  logic             any;
  logic [IW-1:0]    win;

  rga_above_mask #(.DEPTH(DEPTH), .IW(IW)) u_mask (
    .ptr   (ptr_q),
    .above (above)
  );

  rga_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
    .req   (req),
    .above (above),
    .any   (any),
    .win   (win)
  );

  always_comb begin
    grant    = any ? win : '0;
    ptr_next = any ? win : ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ptr_next != ptr_q) begin
      ptr_q <= ptr_next;
    end
  end
endmodule

// File: rtl/rotary_grant_arb_chk.sv
`timescale 1ns/1ps
module rotary_grant_arb_chk #(
  parameter int DEPTH = 13,
  localparam int IW   = rga_pkg::idx_width(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [DEPTH-1:0] req,
  input logic [IW-1:0]    grant,
  input logic [IW-1:0]    ptr_next,
  input logic [IW-1:0]    ptr_q
);
  // R1: an active request set always yields a grant on an asserted line
  a_r1_grant_active: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> req[grant]);

  // R2: idle cycle leaves grant at 0 and the pointer unchanged
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (grant == '0 && ptr_next == ptr_q));

  // R3: next pointer follows the winner
  a_r3_ptr_follows: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (ptr_next == grant));

  // R4: synchronous reset clears the stored pointer
  a_r4_reset_clear: assert property (@(posedge clk)
    rst |=> (ptr_q == '0));

  // R5: pointer loads the presented next value
  a_r5_ptr_load: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ptr_q == $past(ptr_next)));

  // R6: indices stay inside the line count
  a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
    (32'(grant) < DEPTH) && (32'(ptr_q) < DEPTH));
endmodule

bind rotary_grant_arb rotary_grant_arb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .grant    (grant),
  .ptr_next (ptr_next),
  .ptr_q    (ptr_q)
);

// File: tb/rotary_grant_arb_test.sv
`timescale 1ns/1ps
module rotary_grant_arb_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req_b = '0;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk; // 125 MHz

  logic [3:0] g13, n13, g16, n16;
  logic [2:0] g7, n7, g8, n8;

  rotary_grant_arb #(.DEPTH(13)) uut (
    .clk(clk), .rst(rst), .req(req_b[12:0]), .grant(g13), .ptr_next(n13));
  rotary_grant_arb #(.DEPTH(7)) u_d7 (
    .clk(clk), .rst(rst), .req(req_b[6:0]), .grant(g7), .ptr_next(n7));
  rotary_grant_arb #(.DEPTH(8)) u_d8 (
    .clk(clk), .rst(rst), .req(req_b[7:0]), .grant(g8), .ptr_next(n8));
  rotary_grant_arb #(.DEPTH(16)) u_d16 (
    .clk(clk), .rst(rst), .req(req_b), .grant(g16), .ptr_next(n16));

  int dep [4] = '{7, 8, 13, 16};
  int mptr [4] = '{0, 0, 0, 0};

  // Stimulus {req, expected grant, expected next pointer} for DEPTH 13,
  // starting from a pointer of 0 after reset.
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {16'h0001, 4'd0,  4'd0},   // R1 wrap to the pointer line itself
    {16'h0006, 4'd1,  4'd1},   // R1 first above pointer
    {16'h0006, 4'd2,  4'd2},   // R7 not fixed lowest-first
    {16'h0006, 4'd1,  4'd1},   // R1 wrap
    {16'h1000, 4'd12, 4'd12},  // R6 top line
    {16'h1001, 4'd0,  4'd0},   // R6 wrap from the top line
    {16'h0010, 4'd4,  4'd4},
    {16'h0000, 4'd0,  4'd4},   // R2 idle keeps pointer
    {16'h1FFF, 4'd5,  4'd5},   // R1 all active
    {16'h0020, 4'd5,  4'd5},   // R1 only the pointer line
    {16'h0018, 4'd3,  4'd3}    // R7 not downward rotation
  };

  function automatic int ref_pick(input logic [15:0] r, input int d, input int p);
    for (int k = 1; k <= d; k++) begin
      int ix = (p + k) % d;
      if (r[ix]) return ix;
    end
    return -1;
  endfunction

  function automatic int out_g(input int j);
    case (j)
      0: return int'(g7);
      1: return int'(g8);
      2: return int'(g13);
      default: return int'(g16);
    endcase
  endfunction

  function automatic int out_n(input int j);
    case (j)
      0: return int'(n7);
      1: return int'(n8);
      2: return int'(n13);
      default: return int'(n16);
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, compare all instances against the model,
  // then advance the model pointers at the rising edge.
  task automatic step(input logic [15:0] r, input logic rs);
    @(negedge clk);
    req_b = r;
    rst   = rs;
    #1;
    for (int j = 0; j < 4; j++) begin
      int w = ref_pick(r, dep[j], mptr[j]);
      if (w >= 0) begin
        chk($sformatf("R1 grant d%0d", dep[j]), out_g(j), w);
        chk($sformatf("R3 ptr_next d%0d", dep[j]), out_n(j), w);
      end else begin
        chk($sformatf("R2 idle grant d%0d", dep[j]), out_g(j), 0);
        chk($sformatf("R2 idle ptr_next d%0d", dep[j]), out_n(j), mptr[j]);
      end
      chk($sformatf("R6 range d%0d", dep[j]), int'(out_g(j) < dep[j]), 1);
    end
    @(posedge clk);
    for (int j = 0; j < 4; j++) begin
      int w = ref_pick(r, dep[j], mptr[j]);
      if (rs) mptr[j] = 0;
      else if (w >= 0) mptr[j] = w; // R5 load
    end
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // Reset state: R4
    step(16'h0000, 1'b1);
    step(16'h0000, 1'b1);
    step(16'h0000, 1'b0);
    chk("R4 reset ptr_next", int'(n13), 0);
    chk("R4 reset grant", int'(g13), 0);

    // Table walk for the DEPTH 13 instance
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req_b = VEC[v][23:8];
      rst   = 1'b0;
      #1;
      chk($sformatf("R1/R7 table %0d grant", v), int'(g13), int'(VEC[v][7:4]));
      chk($sformatf("R3/R2 table %0d ptr_next", v), int'(n13), int'(VEC[v][3:0]));
      @(posedge clk);
      for (int j = 0; j < 4; j++) begin
        int w = ref_pick(VEC[v][23:8], dep[j], mptr[j]);
        if (w >= 0) mptr[j] = w;
      end
    end

    // R5: pointer from the last table entry (3) drives the next search
    step(16'h000A, 1'b0);
    chk("R5 pointer 3 picks line 1 by wrap", int'(g13), 1);

    // Mid-run reset: R4 pointer back to 0, then line 1 wins over line 0
    step(16'h0100, 1'b0);
    step(16'hFFFF, 1'b1);
    step(16'h0003, 1'b0);
    chk("R4 mid-run reset then grant", int'(g13), 1);

    // Random traffic with occasional resets: R1 R2 R3 R5 R6
    for (int c = 0; c < 3000; c++) begin
      logic [15:0] r;
      int sel = $urandom % 4;
      if (sel == 0) r = 16'(1 << ($urandom % 16));
      else if (sel == 1) r = 16'h0000;
      else r = 16'($urandom);
      step(r, ($urandom % 61) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule